// File: doc/BRIEF.md
# Converter Status Flag Register

This block holds the eight-bit, read-only status byte of a sigma-delta converter's control interface. Four flags are kept: data ready, calibration complete, error and clock lock. The conversion engine drives them with one-cycle event pulses:

- a result has been written;
- the result written was clamped;
- a calibration has finished;
- a calibration has failed;
- a new result is about to land.

A mode-register write strobe clears the flags when a new conversion or calibration starts. The lock flag follows the PLL lock level.

A read begins with a one-cycle select strobe from the serial register decoder when status address 0000 is chosen. At that strobe the byte is captured into a shift register. Each shift strobe then moves the next bit onto the serial data line, most significant bit first. The ready flag is cleared by the read only once all eight bits have left. An active-low ready pin always shows the complement of the ready flag.

Top module: `cnv_status_reg`

## Requirements
- R1: After reset the status byte is 0x00, `ready_n_o` is 1 and `sdo_o` is 0.
- R2: A `res_wr_i` or `cal_done_i` pulse sets the ready flag (bit 7) on that clock edge, and `ready_n_o` is always its complement.
- R3: A `pre_upd_i` or `mode_wr_i` pulse clears the ready flag, and it stays clear until the next set event.
- R4: A read clears the ready flag on the edge of the eighth shift, and not on any earlier shift.
- R5: A `cal_done_i` pulse sets the calibration flag (bit 5) on the same edge as the ready flag. Only `mode_wr_i` clears it; a read does not.
- R6: The error flag (bit 3) is set by `res_wr_i` with `res_clamp_i` high, or by `cal_fail_i`. Only `mode_wr_i` clears it.
- R7: The lock flag (bit 0) equals `pll_lock_i` registered by one clock. Bits 6, 4, 2 and 1 are always 0.
- R8: `rd_sel_i` captures the byte. `sdo_o` then shows bit 7, and each `shift_i` advances one bit toward bit 0. Flag changes after the capture do not alter the bits being sent.
- R9: When a set event and a clear event for the same flag arrive on the same edge, the flag ends up set.
- R10: With no read in progress, `shift_i` has no effect and `sdo_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| res_wr_i | input | 1 | Result written to data register (pulse) |
| res_clamp_i | input | 1 | Qualifies `res_wr_i`: result was clamped |
| cal_done_i | input | 1 | Calibration finished (pulse) |
| cal_fail_i | input | 1 | Calibration could not update its registers (pulse) |
| pre_upd_i | input | 1 | A new result is about to be written (pulse) |
| mode_wr_i | input | 1 | Mode write starting a conversion or calibration (pulse) |
| pll_lock_i | input | 1 | PLL lock level |
| rd_sel_i | input | 1 | Start a read of the status byte (pulse) |
| shift_i | input | 1 | Advance the serial output by one bit |
| sdo_o | output | 1 | Serial data, MSB first |
| ready_n_o | output | 1 | Active-low ready pin |

## Verification
The hardest case to reach is a flag that changes while a read is in progress. The captured byte must still go out unchanged, and the ready flag must survive seven shifts and drop only on the eighth. The stimulus sets ready, starts a read, and injects a calibration failure after the first shift. It then checks that the byte sent omits the error bit and that the next read shows it. A second directed test watches `ready_n_o` after every individual shift. Same-edge set and clear collisions are reached through table rows that pulse both strobes together.

// File: rtl/cnv_status_reg.sv
module cnv_status_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic res_wr_i,
  input  logic res_clamp_i,
  input  logic cal_done_i,
  input  logic cal_fail_i,
  input  logic pre_upd_i,
  input  logic mode_wr_i,
  input  logic pll_lock_i,
  input  logic rd_sel_i,
  input  logic shift_i,
  output logic sdo_o,
  output logic ready_n_o
);
  localparam int W  = 8;
  localparam int CW = $clog2(W + 1);

  logic          rdy_q, cal_q, err_q, lock_q;
  logic [W-1:0]  sh_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  status;
  logic          busy, last_shift, rdy_set, rdy_clr, err_set;

  assign status     = {rdy_q, 1'b0, cal_q, 1'b0, err_q, 2'b00, lock_q};
  assign busy       = (cnt_q != '0);
  assign last_shift = busy && shift_i && (cnt_q == CW'(1));
  assign rdy_set    = res_wr_i | cal_done_i;
  assign rdy_clr    = pre_upd_i | mode_wr_i | last_shift;
  assign err_set    = (res_wr_i & res_clamp_i) | cal_fail_i;
  assign sdo_o      = busy & sh_q[W-1];
  assign ready_n_o  = ~rdy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      cal_q  <= 1'b0;
      err_q  <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      lock_q <= pll_lock_i;
      if (rdy_set)             rdy_q <= 1'b1;
      else if (rdy_clr)        rdy_q <= 1'b0;
      if (cal_done_i)          cal_q <= 1'b1;
      else if (mode_wr_i)      cal_q <= 1'b0;
      if (err_set)             err_q <= 1'b1;
      else if (mode_wr_i)      err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rd_sel_i) begin
      sh_q  <= status;
      cnt_q <= CW'(W);
    end else if (busy && shift_i) begin
      sh_q  <= {sh_q[W-2:0], 1'b0};
      cnt_q <= cnt_q - CW'(1);
    end
  end
endmodule

// File: rtl/cnv_status_reg_chk.sv
module cnv_status_reg_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       res_wr_i,
  input logic       cal_done_i,
  input logic       pre_upd_i,
  input logic       mode_wr_i,
  input logic       pll_lock_i,
  input logic       sdo_o,
  input logic       ready_n_o,
  input logic       cal_q,
  input logic       lock_q,
  input logic [3:0] cnt_q
);
  logic blk_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blk_q <= 1'b0;
    else if (res_wr_i || cal_done_i) blk_q <= 1'b0;
    else if (pre_upd_i) blk_q <= 1'b1;
  end

  a_r2_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (res_wr_i || cal_done_i) |=> !ready_n_o);
  a_r3_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_upd_i && !res_wr_i && !cal_done_i) |=> ready_n_o);
  a_r3_window_low: assert property (@(posedge clk) disable iff (!rst_n)
    blk_q |-> ready_n_o);
  a_r5_cal_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_q && !mode_wr_i) |=> cal_q);
  a_r9_cal_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done_i && mode_wr_i) |=> cal_q);
  a_r7_lock_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lock_q == $past(pll_lock_i)));
  a_r10_idle_sdo: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == 4'd0) |-> !sdo_o);
endmodule

bind cnv_status_reg cnv_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .res_wr_i(res_wr_i), .cal_done_i(cal_done_i),
  .pre_upd_i(pre_upd_i), .mode_wr_i(mode_wr_i), .pll_lock_i(pll_lock_i),
  .sdo_o(sdo_o), .ready_n_o(ready_n_o), .cal_q(cal_q), .lock_q(lock_q),
  .cnt_q(cnt_q)
);

// File: tb/cnv_status_reg_tb.sv
module cnv_status_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;
  // {lock, res_wr, clamp, cal_done, cal_fail, pre_upd, mode_wr, expected byte}
  localparam logic [14:0] VEC [NV] = '{
    {7'b1100000, 8'h81}, {7'b1110000, 8'h89}, {7'b1000000, 8'h09},
    {7'b1000001, 8'h01}, {7'b1001000, 8'hA1}, {7'b0100010, 8'hA0},
    {7'b0001001, 8'hA0}, {7'b0000100, 8'h28}, {7'b0000001, 8'h00},
    {7'b1001100, 8'hA9}, {7'b1000001, 8'h01}
  };

  logic clk = 0, rst_n = 0;
  logic res_wr_i = 0, res_clamp_i = 0, cal_done_i = 0, cal_fail_i = 0;
  logic pre_upd_i = 0, mode_wr_i = 0, pll_lock_i = 0, rd_sel_i = 0, shift_i = 0;
  logic sdo_o, ready_n_o;
  int checks = 0, fails = 0;
  logic [7:0] rb;

  always #(CLK_PERIOD/2) clk = ~clk;

  cnv_status_reg u_dut (.*);

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(logic [6:0] ev);
    @(negedge clk);
    pll_lock_i = ev[6]; res_wr_i = ev[5]; res_clamp_i = ev[4];
    cal_done_i = ev[3]; cal_fail_i = ev[2]; pre_upd_i = ev[1]; mode_wr_i = ev[0];
    @(negedge clk);
    res_wr_i = 0; res_clamp_i = 0; cal_done_i = 0; cal_fail_i = 0;
    pre_upd_i = 0; mode_wr_i = 0;
  endtask

  task automatic read_byte(output logic [7:0] b);
    rd_sel_i = 1;
    @(negedge clk);
    rd_sel_i = 0;
    for (int i = 7; i >= 0; i--) begin
      b[i] = sdo_o;
      shift_i = 1;
      @(negedge clk);
      shift_i = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 ready_n after reset", {7'b0, ready_n_o}, 8'h01);
    check("R1 sdo after reset", {7'b0, sdo_o}, 8'h00);
    rst_n = 1;
    @(negedge clk);
    read_byte(rb);
    check("R1 byte after reset", rb, 8'h00);

    // table: R2 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      pulse(VEC[v][14:8]);
      @(negedge clk);
      read_byte(rb);
      check($sformatf("R2/R5/R6/R7/R8/R9 vector %0d", v), rb, VEC[v][7:0]);
    end

    // R3: pre-update window keeps ready low until the result lands
    pulse(7'b0100000);
    check("R2 ready_n low after result", {7'b0, ready_n_o}, 8'h00);
    pulse(7'b0000010);
    for (int k = 0; k < 3; k++) begin
      check("R3 ready_n high in window", {7'b0, ready_n_o}, 8'h01);
      @(negedge clk);
    end
    pulse(7'b0100000);
    check("R2 ready after window", {7'b0, ready_n_o}, 8'h00);
    pulse(7'b0000001);
    check("R3 mode write clears ready", {7'b0, ready_n_o}, 8'h01);

    // R4: ready drops only on the eighth shift
    pulse(7'b0100000);
    rd_sel_i = 1;
    @(negedge clk);
    rd_sel_i = 0;
    for (int i = 0; i < 8; i++) begin
      shift_i = 1;
      @(negedge clk);
      shift_i = 0;
      check($sformatf("R4 ready_n after shift %0d", i + 1), {7'b0, ready_n_o},
            (i == 7) ? 8'h01 : 8'h00);
    end

    // R8: byte captured at select; error raised mid-read is not sent
    pulse(7'b0100000);
    rd_sel_i = 1;
    @(negedge clk);
    rd_sel_i = 0;
    rb[7] = sdo_o;
    shift_i = 1; cal_fail_i = 1;
    @(negedge clk);
    shift_i = 0; cal_fail_i = 0;
    for (int i = 6; i >= 0; i--) begin
      rb[i] = sdo_o;
      shift_i = 1;
      @(negedge clk);
      shift_i = 0;
    end
    check("R8 captured byte", rb, 8'h80);
    read_byte(rb);
    check("R8 next read shows error", rb, 8'h08);

    // R10: shifts with no read in progress do nothing
    for (int i = 0; i < 4; i++) begin
      shift_i = 1;
      @(negedge clk);
      check("R10 idle sdo", {7'b0, sdo_o}, 8'h00);
    end
    shift_i = 0;
    read_byte(rb);
    check("R10 byte intact after idle shifts", rb, 8'h08);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule